// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Forwarding

This block sits in front of a primary interrupt controller and collects 32 level-sensitive interrupt sources. A source counts toward one combined request, driven on output line 31, when its bit is enabled in a mask register. A band of sources (lines 21 to 30) can also bypass the combiner. When the forwarding-enable bit of one of these lines is set, that source is copied onto the primary output with the same index.

Software reaches the block over a simple synchronous 32-bit register bus inside a 4 KB window. Registers are selected by word index, which is the byte address shifted right by two. The mask and the forwarding enables are changed only through set and clear words, so separate drivers can update them without a read-modify-write. A pair of software-interrupt words controls mask bit 0 on its own.

The input levels are captured once per clock into a raw-level register. All outputs and readable state are derived from that register, the mask and the forwarding enables.

Top module: `irq_combiner`

## Requirements
- R1: While `rst_ni` is low, the raw level, the mask and the forwarding enables are zero, so every read listed below returns zero and `irq_o` is all zero, whatever `irq_i` holds.
- R2: Each clock edge out of reset copies `irq_i` into the raw level. Reading byte 0x004 (word 1) returns it.
- R3: Reading byte 0x000 (word 0) returns the raw level ANDed with the mask.
- R4: A write to byte 0x008 (word 2) ORs `wdata_i` into the mask. Reading byte 0x008 returns the mask.
- R5: A write to byte 0x00C (word 3) clears each mask bit that is 1 in `wdata_i`.
- R6: Reading byte 0x010 (word 4) returns raw level bit 0 in bit 0, with all other bits zero. A nonzero write to 0x010 sets mask bit 0, and a nonzero write to byte 0x014 (word 5) clears it. A zero write to either word leaves the mask unchanged.
- R7: A write to byte 0x020 (word 8) ORs `wdata_i & 32'h7FE0_0000` into the forwarding enables. A write to byte 0x024 (word 9) clears the enable bits that are 1 in `wdata_i`. Reading 0x020 returns the enables.
- R8: `irq_o[31]` is high exactly when the raw level ANDed with the mask is nonzero.
- R9: For each i from 21 to 30, `irq_o[i]` equals raw level bit i when forwarding-enable bit i is set. Otherwise it is low.
- R10: `irq_o[20:0]` is always zero.
- R11: Reads of every other word return zero, including words 3, 5 and 9. Writes to words other than 2, 3, 4, 5, 8 and 9 change no state.
- R12: A write takes effect on the clock edge at which `we_i` is sampled high. `rdata_o` is combinational from `addr_i` and the current register state, so in the cycle that strobes a write it still shows the old value. Without a write, the mask and the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address within the register window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_i | input | 32 | Level-sensitive interrupt sources |
| irq_o | output | 32 | Lines toward the primary controller |

## Verification
A corrupted mask bit shows up on `irq_o[31]` in the next cycle in which the matching source is high. It also shows up at once in a combinational read of the status or mask word.

A forwarding-enable bit that is wrongly set, or set outside the band, would copy a source onto a line that must stay low. The checks look for this on the band lines and on the low lines.

The cases that matter most are the ones that look alike: a zero write to the software-interrupt words, a read of the clear-only words, and an enable-clear that overlaps only part of the mask. Each of these is checked against an expected value that the bench computes on its own, one cycle after its stimulus.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int unsigned NUM_LINES  = 32;
  localparam int unsigned WIN_ADDR_W = 12;
  localparam int unsigned WORD_IDX_W = WIN_ADDR_W - 2;

  typedef enum logic [WORD_IDX_W-1:0] {
    W_STATUS   = 'd0,
    W_RAW      = 'd1,
    W_EN_SET   = 'd2,
    W_EN_CLR   = 'd3,
    W_SOFT_SET = 'd4,
    W_SOFT_CLR = 'd5,
    W_FWD_SET  = 'd8,
    W_FWD_CLR  = 'd9
  } word_e;

  function automatic logic [NUM_LINES-1:0] band_mask(int unsigned lo, int unsigned hi);
    logic [NUM_LINES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_LINES; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_combiner_level.sv
module irq_combiner_level #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] irq_i,
  output logic [W-1:0] raw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= '0;
    else         raw_o <= irq_i;
  end
endmodule

// File: rtl/irq_combiner_regs.sv
module irq_combiner_regs
  import irq_combiner_pkg::*;
#(
  parameter int unsigned  W     = 32,
  parameter int unsigned  IDX_W = 10,
  parameter logic [W-1:0] BAND  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] word_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     raw_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     mask_o,
  output logic [W-1:0]     fwd_o
);
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] fwd_q, fwd_d;
  logic         wr_nonzero;

  assign wr_nonzero = |wdata_i;

  always_comb begin
    mask_d = mask_q;
    fwd_d  = fwd_q;
    if (we_i) begin
      case (word_i)
        W_EN_SET:   mask_d = mask_q | wdata_i;
        W_EN_CLR:   mask_d = mask_q & ~wdata_i;
        W_SOFT_SET: if (wr_nonzero) mask_d[0] = 1'b1;
        W_SOFT_CLR: if (wr_nonzero) mask_d[0] = 1'b0;
        W_FWD_SET:  fwd_d  = fwd_q | (wdata_i & BAND);
        W_FWD_CLR:  fwd_d  = fwd_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      fwd_q  <= '0;
    end else begin
      mask_q <= mask_d;
      fwd_q  <= fwd_d;
    end
  end

  // read path is combinational from current state
  always_comb begin
    case (word_i)
      W_STATUS:   rdata_o = raw_i & mask_q;
      W_RAW:      rdata_o = raw_i;
      W_EN_SET:   rdata_o = mask_q;
      W_SOFT_SET: rdata_o = W'(raw_i[0]);
      W_FWD_SET:  rdata_o = fwd_q;
      default:    rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign fwd_o  = fwd_q;
endmodule

// File: rtl/irq_combiner_route.sv
module irq_combiner_route #(
  parameter int unsigned  W        = 32,
  parameter int unsigned  FWD_LO   = 21,
  parameter int unsigned  FWD_HI   = 30,
  parameter int unsigned  COMB_IDX = 31,
  parameter logic [W-1:0] BAND     = '0
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] fwd_i,
  output logic [W-1:0] irq_o
);
  logic comb_req;
  logic unused_fwd_bits;

  assign comb_req        = |(raw_i & mask_i);
  assign unused_fwd_bits = ^(fwd_i & ~BAND);

  for (genvar i = 0; i < W; i++) begin : g_line
    if (i == COMB_IDX) begin : g_comb
      assign irq_o[i] = comb_req;
    end else if (i >= FWD_LO && i <= FWD_HI) begin : g_fwd
      assign irq_o[i] = raw_i[i] & fwd_i[i];
    end else begin : g_quiet
      assign irq_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned FWD_LO   = 21,
  parameter int unsigned FWD_HI   = 30,
  parameter int unsigned COMB_IDX = 31
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIN_ADDR_W-1:0] addr_i,
  input  logic                  we_i,
  input  logic [NUM_LINES-1:0]  wdata_i,
  output logic [NUM_LINES-1:0]  rdata_o,
  input  logic [NUM_LINES-1:0]  irq_i,
  output logic [NUM_LINES-1:0]  irq_o
);
  localparam logic [NUM_LINES-1:0] BAND = band_mask(FWD_LO, FWD_HI);

  logic [NUM_LINES-1:0]  raw_q;
  logic [NUM_LINES-1:0]  mask_q;
  logic [NUM_LINES-1:0]  fwd_q;
  logic [WORD_IDX_W-1:0] word_idx;
  logic                  unused_byte_lane;

  assign word_idx         = addr_i[WIN_ADDR_W-1:2];
  assign unused_byte_lane = ^addr_i[1:0];

  irq_combiner_level #(.W(NUM_LINES)) i_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .raw_o  (raw_q)
  );

  irq_combiner_regs #(.W(NUM_LINES), .IDX_W(WORD_IDX_W), .BAND(BAND)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (word_idx),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .raw_i   (raw_q),
    .rdata_o (rdata_o),
    .mask_o  (mask_q),
    .fwd_o   (fwd_q)
  );

  irq_combiner_route #(
    .W(NUM_LINES), .FWD_LO(FWD_LO), .FWD_HI(FWD_HI), .COMB_IDX(COMB_IDX), .BAND(BAND)
  ) i_route (
    .raw_i  (raw_q),
    .mask_i (mask_q),
    .fwd_i  (fwd_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned AW    = 12,
  parameter logic [W-1:0] BAND = 32'h7FE0_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic [W-1:0]  irq_i,
  input logic [W-1:0]  irq_o,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  fwd
);
  logic [AW-3:0] wi;
  logic          seen_q;
  logic          wr_undef;
  logic          rd_undef;

  assign wi       = addr_i[AW-1:2];
  assign wr_undef = !(wi inside {2, 3, 4, 5, 8, 9});
  assign rd_undef = !(wi inside {0, 1, 2, 4, 8});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0 && mask == '0 && fwd == '0));

  p_raw_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (wi == 1) |-> (rdata_o == $past(irq_i)));

  p_en_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wi == 2) |=> ((mask & $past(wdata_i)) == $past(wdata_i)));

  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wi == 3) |=> ((mask & $past(wdata_i)) == '0));

  p_fwd_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wi == 8) |=> (fwd == ($past(fwd) | ($past(wdata_i) & BAND))));

  p_comb_vs_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wi == 0) |-> (irq_o[W-1] == (rdata_o != '0)));

  p_fwd_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & BAND & ~fwd) == '0));

  p_undef_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_undef |-> (rdata_o == '0));

  p_undef_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_undef) |=> ($stable(mask) && $stable(fwd)));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mask) && $stable(fwd)));
endmodule

bind irq_combiner irq_combiner_chk #(
  .W(irq_combiner_pkg::NUM_LINES), .AW(irq_combiner_pkg::WIN_ADDR_W), .BAND(BAND)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_i   (irq_i),
  .irq_o   (irq_o),
  .mask    (mask_q),
  .fwd     (fwd_q)
);

// File: tb/test_irq_combiner.sv
`timescale 1ns/1ps
module test_irq_combiner;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] irq_i = 32'hFFFF_FFFF;
  logic [31:0] irq_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  irq_combiner i_irq_combiner (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // monitor: samples mid low phase, away from the rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? irq_o : rdata_o;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s act=%h exp=%h", it.tag, it.is_irq ? "irq_o" : "rdata_o", act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    sb_q.push_back('{1'b0, e, tag});
  endtask

  task automatic ck_irq(input logic [31:0] e, input string tag);
    @(negedge clk_i);
    we_i = 1'b0;
    sb_q.push_back('{1'b1, e, tag});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  // strobes a write and checks that the read in that cycle still shows old state
  task automatic wr_chk(input logic [11:0] a, input logic [31:0] d, input logic [31:0] old, input string tag);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    sb_q.push_back('{1'b0, old, tag});
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk_i);
    we_i = 1'b0; irq_i = v;
  endtask

  initial begin
    // R1: in reset with all sources high
    rd(12'h004, 32'h0, "R1 raw");
    rd(12'h008, 32'h0, "R1 mask");
    rd(12'h020, 32'h0, "R1 fwd");
    ck_irq(32'h0, "R1 irq_o");
    @(negedge clk_i); rst_ni = 1'b1; irq_i = 32'h0;

    set_irq(32'hA5A5_0F0F);
    rd(12'h004, 32'hA5A5_0F0F, "R2 raw");
    ck_irq(32'h0, "R8 masked off");

    wr(12'h008, 32'h0000_00FF);
    rd(12'h008, 32'h0000_00FF, "R4 set");
    wr(12'h008, 32'hF000_0000);
    rd(12'h008, 32'hF000_00FF, "R4 or");
    rd(12'h000, 32'hA000_000F, "R3 status");
    ck_irq(32'h8000_0000, "R8 combined");

    wr(12'h00C, 32'hA000_000F);
    rd(12'h008, 32'h5000_00F0, "R5 clear");
    rd(12'h000, 32'h0, "R3 status empty");
    ck_irq(32'h0, "R8 deassert");

    rd(12'h010, 32'h1, "R6 soft read");
    wr(12'h010, 32'h0);
    rd(12'h008, 32'h5000_00F0, "R6 zero set");
    wr(12'h010, 32'h100);
    rd(12'h008, 32'h5000_00F1, "R6 set");
    rd(12'h000, 32'h1, "R6 status");
    ck_irq(32'h8000_0000, "R6 combined");
    wr(12'h014, 32'h0);
    rd(12'h008, 32'h5000_00F1, "R6 zero clr");
    wr(12'h014, 32'h8000_0000);
    rd(12'h008, 32'h5000_00F0, "R6 clr");
    set_irq(32'hA5A5_0F0E);
    rd(12'h010, 32'h0, "R6 soft read low");
    ck_irq(32'h0, "R6 irq idle");

    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, 32'h7FE0_0000, "R7 band only");
    ck_irq(32'h25A0_0000, "R9 forward");
    wr(12'h024, 32'h0520_0000);
    rd(12'h020, 32'h7AC0_0000, "R7 clear");
    ck_irq(32'h2080_0000, "R9 partial");
    set_irq(32'h7FFF_FFFF);
    ck_irq(32'hFAC0_0000, "R9 follow");

    wr(12'h008, 32'h001F_FFFF);
    set_irq(32'hFFFF_FFFF);
    ck_irq(32'hFAC0_0000, "R10 low lines");

    rd(12'h018, 32'h0, "R11 word6");
    rd(12'h00C, 32'h0, "R11 word3");
    rd(12'h014, 32'h0, "R11 word5");
    rd(12'h024, 32'h0, "R11 word9");
    rd(12'hFFC, 32'h0, "R11 top");
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h008, 32'h501F_FFFF, "R11 mask kept");
    rd(12'h020, 32'h7AC0_0000, "R11 fwd kept");

    wr(12'h00C, 32'hFFFF_FFFF);
    wr_chk(12'h008, 32'h0000_0001, 32'h0, "R12 old value");
    rd(12'h008, 32'h0000_0001, "R12 new value");
    rd(12'h000, 32'h0000_0001, "R12 status");

    @(negedge clk_i);
    we_i = 1'b0;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule